// File: doc/BRIEF.md
# Microcode ALU with Function Select and Carry Latch

This block is the arithmetic and logic stage of a microcoded processor datapath. Each cycle it combines the shared data bus with the contents of its own T register. A 4-bit function code picks the operation, and a one-bit skip input feeds one of the increment forms. The result and its carry are available in the same cycle. The block also reports whether the selected function routes the ALU output into T, so the next-state logic can see where a T load will take its value from.

Two registers sit behind the ALU. L captures the result when its load strobe is high. T captures either the result or the raw bus value when its load strobe is high. A one-bit carry latch records the carry of the last operation that loaded L, so later microinstructions can branch on it. All arithmetic is modulo 2^W, and subtraction is two's complement. A carry of 1 on a subtract therefore means that no borrow occurred.

Top module: `mcode_alu`

## Requirements
- R1: Codes 0 (BUS), 1 (T), 2 (BUS|T), 3 (BUS&T), 4 (BUS^T), 12 (BUS&T) and 13 (BUS&~T) give that bitwise result on alu_o, with carry_o = 0.
- R2: Code 5 gives BUS+1 and code 6 gives BUS-1 (computed as BUS+all-ones). carry_o is the carry out of the W-bit sum.
- R3: Code 7 gives BUS+T and code 10 gives BUS+T+1. carry_o is the carry out of the W-bit sum.
- R4: Code 8 gives BUS-T (BUS+~T+1) and code 9 gives BUS-T-1 (BUS+~T). carry_o is 1 exactly when no borrow occurs.
- R5: Code 11 gives BUS+skip_i, with skip_i added as 0 or 1. carry_o is the carry out of that sum.
- R6: Codes 14 and 15 pass BUS unchanged to alu_o, with carry_o = 0.
- R7: t_from_alu_o is 1 for codes 1, 2, 5, 6, 10, 11 and 12, and 0 for every other code.
- R8: On a clock edge with load_l_i high, l_o takes alu_o. With load_l_i low, l_o holds its value.
- R9: l_carry_o takes carry_o only on an edge with load_l_i high, and holds its value on every other edge.
- R10: On an edge with load_t_i high, t_o takes alu_o when t_from_alu_o is 1 and bus_i otherwise. With load_t_i low, t_o holds its value.
- R11: While rst_ni is low, l_o, t_o and l_carry_o are 0, independent of the clock.
- R12: When load_l_i and load_t_i are both high in one cycle, both registers are loaded from the result computed with the T value held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | W | Bus operand |
| func_i | input | 4 | ALU function code |
| skip_i | input | 1 | Increment applied by code 11 |
| load_l_i | input | 1 | Load strobe for L and the carry latch |
| load_t_i | input | 1 | Load strobe for T |
| alu_o | output | W | ALU result |
| carry_o | output | 1 | Carry of the current operation |
| t_from_alu_o | output | 1 | Selected code routes the ALU result into T |
| l_o | output | W | L register |
| t_o | output | W | T register, also the second operand |
| l_carry_o | output | 1 | Carry latched at the last L load |

## Verification
The collision of interest is an L load and a T load in the same cycle. Both registers then depend on a result that itself reads T. The bench presets T and selects code 10, which is in the T-from-ALU class. It raises both strobes together and checks that L and T hold the same sum formed from the old T. It then checks that the next combinational result uses the new T. The carry latch is probed the same way: an operation with a different carry runs without an L load, and the latch must keep its earlier value.

// File: rtl/mcode_alu_pkg.sv
package mcode_alu_pkg;
  localparam int unsigned FN_W = 4;

  typedef enum logic [FN_W-1:0] {
    FN_PASS = 4'd0,  FN_T    = 4'd1,  FN_OR   = 4'd2,  FN_AND  = 4'd3,
    FN_XOR  = 4'd4,  FN_INC  = 4'd5,  FN_DEC  = 4'd6,  FN_ADD  = 4'd7,
    FN_SUB  = 4'd8,  FN_SUBD = 4'd9,  FN_ADDI = 4'd10, FN_SKIP = 4'd11,
    FN_ANDT = 4'd12, FN_ANDN = 4'd13, FN_RSV0 = 4'd14, FN_RSV1 = 4'd15
  } alu_fn_e;

  // codes whose result may be written to T
  function automatic logic fn_feeds_t(input alu_fn_e fn);
    unique case (fn)
      FN_T, FN_OR, FN_INC, FN_DEC, FN_ADDI, FN_SKIP, FN_ANDT: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mcode_alu_core.sv
module mcode_alu_core
  import mcode_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]    bus_i,
  input  logic [W-1:0]    t_i,
  input  logic [FN_W-1:0] func_i,
  input  logic            skip_i,
  output logic [W-1:0]    res_o,
  output logic            carry_o,
  output logic            feeds_t_o
);
  alu_fn_e      fn;
  logic         use_adder;
  logic [W-1:0] add_b;
  logic         add_cin;
  logic [W-1:0] logic_res;
  logic [W:0]   sum;

  assign fn = alu_fn_e'(func_i);

  // one shared adder: operand and carry-in chosen per code
  always_comb begin
    use_adder = 1'b1;
    add_b     = '0;
    add_cin   = 1'b0;
    logic_res = bus_i;
    unique case (fn)
      FN_T:    begin use_adder = 1'b0; logic_res = t_i; end
      FN_OR:   begin use_adder = 1'b0; logic_res = bus_i | t_i; end
      FN_AND,
      FN_ANDT: begin use_adder = 1'b0; logic_res = bus_i & t_i; end
      FN_XOR:  begin use_adder = 1'b0; logic_res = bus_i ^ t_i; end
      FN_ANDN: begin use_adder = 1'b0; logic_res = bus_i & ~t_i; end
      FN_INC:  add_cin = 1'b1;
      FN_DEC:  add_b = '1;
      FN_ADD:  add_b = t_i;
      FN_ADDI: begin add_b = t_i; add_cin = 1'b1; end
      FN_SUB:  begin add_b = ~t_i; add_cin = 1'b1; end
      FN_SUBD: add_b = ~t_i;
      FN_SKIP: add_cin = skip_i;
      default: use_adder = 1'b0;  // pass and reserved codes
    endcase
  end

  assign sum       = {1'b0, bus_i} + {1'b0, add_b} + {{W{1'b0}}, add_cin};
  assign res_o     = use_adder ? sum[W-1:0] : logic_res;
  assign carry_o   = use_adder & sum[W];
  assign feeds_t_o = fn_feeds_t(fn);
endmodule

// File: rtl/mcode_alu_regs.sv
module mcode_alu_regs #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] res_i,
  input  logic         carry_i,
  input  logic [W-1:0] bus_i,
  input  logic         feeds_t_i,
  input  logic         load_l_i,
  input  logic         load_t_i,
  output logic [W-1:0] l_o,
  output logic [W-1:0] t_o,
  output logic         l_carry_o
);
  logic [W-1:0] t_next;

  assign t_next = feeds_t_i ? res_i : bus_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l_o       <= '0;
      l_carry_o <= 1'b0;
    end else if (load_l_i) begin
      l_o       <= res_i;
      l_carry_o <= carry_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       t_o <= '0;
    else if (load_t_i) t_o <= t_next;
  end
endmodule

// File: rtl/mcode_alu.sv
module mcode_alu
  import mcode_alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [W-1:0]    bus_i,
  input  logic [FN_W-1:0] func_i,
  input  logic            skip_i,
  input  logic            load_l_i,
  input  logic            load_t_i,
  output logic [W-1:0]    alu_o,
  output logic            carry_o,
  output logic            t_from_alu_o,
  output logic [W-1:0]    l_o,
  output logic [W-1:0]    t_o,
  output logic            l_carry_o
);
  mcode_alu_core #(.W(W)) u_core (
    .bus_i     (bus_i),
    .t_i       (t_o),
    .func_i    (func_i),
    .skip_i    (skip_i),
    .res_o     (alu_o),
    .carry_o   (carry_o),
    .feeds_t_o (t_from_alu_o)
  );

  mcode_alu_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .res_i     (alu_o),
    .carry_i   (carry_o),
    .bus_i     (bus_i),
    .feeds_t_i (t_from_alu_o),
    .load_l_i  (load_l_i),
    .load_t_i  (load_t_i),
    .l_o       (l_o),
    .t_o       (t_o),
    .l_carry_o (l_carry_o)
  );
endmodule

// File: rtl/mcode_alu_chk.sv
module mcode_alu_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] bus_i,
  input logic [3:0]   func_i,
  input logic         load_l_i,
  input logic         load_t_i,
  input logic [W-1:0] alu_o,
  input logic         carry_o,
  input logic         t_from_alu_o,
  input logic [W-1:0] l_o,
  input logic [W-1:0] t_o,
  input logic         l_carry_o
);
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_i inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd12, 4'd13}) |-> !carry_o); // R1
  AST_RSV_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_i >= 4'd14) |-> (alu_o == bus_i && !carry_o)); // R6
  AST_L_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_l_i |=> l_o == $past(alu_o)); // R8
  AST_L_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_l_i |=> $stable(l_o)); // R8
  AST_LC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_l_i |=> l_carry_o == $past(carry_o)); // R9
  AST_LC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_l_i |=> $stable(l_carry_o)); // R9
  AST_T_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_t_i |=> t_o == ($past(t_from_alu_o) ? $past(alu_o) : $past(bus_i))); // R10
  AST_T_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_t_i |=> $stable(t_o)); // R10
  AST_DUAL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_l_i && load_t_i && t_from_alu_o) |=> l_o == t_o); // R12
endmodule

bind mcode_alu mcode_alu_chk #(.W(W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_i        (bus_i),
  .func_i       (func_i),
  .load_l_i     (load_l_i),
  .load_t_i     (load_t_i),
  .alu_o        (alu_o),
  .carry_o      (carry_o),
  .t_from_alu_o (t_from_alu_o),
  .l_o          (l_o),
  .t_o          (t_o),
  .l_carry_o    (l_carry_o)
);

// File: tb/mcode_alu_tb_top.sv
module mcode_alu_tb_top;
  localparam int unsigned W = 16;
  localparam int unsigned NV = 20;

  typedef struct packed {
    logic [15:0] t;
    logic [15:0] bus;
    logic [3:0]  fn;
    logic        sk;
    logic [15:0] res;
    logic        c;
    logic        tsel;
  } vec_t;

  // T preset, bus, code, skip, expected result, carry, T-from-ALU
  localparam vec_t VEC [NV] = '{
    '{16'h1234, 16'hABCD, 4'd0,  1'b0, 16'hABCD, 1'b0, 1'b0},  // R1
    '{16'h1234, 16'hABCD, 4'd1,  1'b0, 16'h1234, 1'b0, 1'b1},  // R1
    '{16'h0FF0, 16'hF0F0, 4'd2,  1'b0, 16'hFFF0, 1'b0, 1'b1},  // R1
    '{16'h0FF0, 16'hF0F0, 4'd3,  1'b0, 16'h00F0, 1'b0, 1'b0},  // R1
    '{16'h0FF0, 16'hF0F0, 4'd4,  1'b0, 16'hFF00, 1'b0, 1'b0},  // R1
    '{16'h0000, 16'hFFFF, 4'd5,  1'b0, 16'h0000, 1'b1, 1'b1},  // R2
    '{16'h0000, 16'h0000, 4'd6,  1'b0, 16'hFFFF, 1'b0, 1'b1},  // R2
    '{16'h0000, 16'h0005, 4'd6,  1'b0, 16'h0004, 1'b1, 1'b1},  // R2
    '{16'h8001, 16'h8000, 4'd7,  1'b0, 16'h0001, 1'b1, 1'b0},  // R3
    '{16'h0003, 16'h0005, 4'd8,  1'b0, 16'h0002, 1'b1, 1'b0},  // R4
    '{16'h0005, 16'h0003, 4'd8,  1'b0, 16'hFFFE, 1'b0, 1'b0},  // R4
    '{16'h0003, 16'h0005, 4'd9,  1'b0, 16'h0001, 1'b1, 1'b0},  // R4
    '{16'h0003, 16'h0003, 4'd9,  1'b0, 16'hFFFF, 1'b0, 1'b0},  // R4
    '{16'h0001, 16'hFFFE, 4'd10, 1'b0, 16'h0000, 1'b1, 1'b1},  // R3
    '{16'h0000, 16'hFFFF, 4'd11, 1'b1, 16'h0000, 1'b1, 1'b1},  // R5
    '{16'h0000, 16'h0010, 4'd11, 1'b0, 16'h0010, 1'b0, 1'b1},  // R5
    '{16'h0FF0, 16'hF0F0, 4'd12, 1'b0, 16'h00F0, 1'b0, 1'b1},  // R1
    '{16'h0FF0, 16'hF0F0, 4'd13, 1'b0, 16'hF000, 1'b0, 1'b0},  // R1
    '{16'hFFFF, 16'h5A5A, 4'd14, 1'b0, 16'h5A5A, 1'b0, 1'b0},  // R6
    '{16'hFFFF, 16'h5A5A, 4'd15, 1'b0, 16'h5A5A, 1'b0, 1'b0}   // R6
  };

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] bus_i = '0;
  logic [3:0]   func_i = '0;
  logic         skip_i = 1'b0;
  logic         load_l_i = 1'b0;
  logic         load_t_i = 1'b0;
  logic [W-1:0] alu_o, l_o, t_o;
  logic         carry_o, t_from_alu_o, l_carry_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  mcode_alu #(.W(W)) dut_i (
    .clk_i, .rst_ni, .bus_i, .func_i, .skip_i, .load_l_i, .load_t_i,
    .alu_o, .carry_o, .t_from_alu_o, .l_o, .t_o, .l_carry_o
  );

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // apply inputs after a falling edge, so they settle before the next rise
  task automatic drive(input logic [W-1:0] b, input logic [3:0] f, input logic s,
                       input logic ll, input logic lt);
    @(negedge clk_i);
    bus_i = b; func_i = f; skip_i = s; load_l_i = ll; load_t_i = lt;
    #1;
  endtask

  task automatic preset_t(input logic [W-1:0] v);
    drive(v, 4'd0, 1'b0, 1'b0, 1'b1);  // code 0 is outside the class: T <= BUS
    drive(v, 4'd0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #50000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #10;
    check("R11", "l_o in reset", l_o, '0);
    check("R11", "t_o in reset", t_o, '0);
    check("R11", "l_carry_o in reset", {15'd0, l_carry_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      preset_t(VEC[i].t);
      drive(VEC[i].bus, VEC[i].fn, VEC[i].sk, 1'b0, 1'b0);
      check("R1-6 table", $sformatf("alu_o code %0d", VEC[i].fn), alu_o, VEC[i].res);
      check("R1-6 table", $sformatf("carry_o code %0d", VEC[i].fn), {15'd0, carry_o}, {15'd0, VEC[i].c});
      check("R7", $sformatf("t_from_alu_o code %0d", VEC[i].fn), {15'd0, t_from_alu_o}, {15'd0, VEC[i].tsel});
    end

    // R8 / R9: L and carry latch capture on load
    preset_t(16'h0003);
    drive(16'h0005, 4'd8, 1'b0, 1'b1, 1'b0);
    drive(16'h0003, 4'd9, 1'b0, 1'b0, 1'b0);
    check("R8", "l_o after load", l_o, 16'h0002);
    check("R9", "l_carry_o after load", {15'd0, l_carry_o}, 16'd1);
    check("R9", "carry_o differs while unloaded", {15'd0, carry_o}, 16'd0);
    drive(16'h0003, 4'd9, 1'b0, 1'b0, 1'b0);
    check("R8", "l_o held", l_o, 16'h0002);
    check("R9", "l_carry_o held", {15'd0, l_carry_o}, 16'd1);
    drive(16'h0003, 4'd9, 1'b0, 1'b1, 1'b0);
    drive(16'h0000, 4'd0, 1'b0, 1'b0, 1'b0);
    check("R8", "l_o reload", l_o, 16'hFFFF);
    check("R9", "l_carry_o reload", {15'd0, l_carry_o}, 16'd0);

    // R10: T source depends on the class
    preset_t(16'h0003);
    drive(16'h0005, 4'd7, 1'b0, 1'b0, 1'b1);
    drive(16'h0000, 4'd0, 1'b0, 1'b0, 1'b0);
    check("R10", "t_o from bus (code 7)", t_o, 16'h0005);
    drive(16'h0005, 4'd5, 1'b0, 1'b0, 1'b1);
    drive(16'h0000, 4'd0, 1'b0, 1'b0, 1'b0);
    check("R10", "t_o from alu (code 5)", t_o, 16'h0006);
    drive(16'h7777, 4'd1, 1'b0, 1'b0, 1'b0);
    check("R10", "t_o held", t_o, 16'h0006);

    // R12: both loads in one cycle use the old T
    preset_t(16'h0010);
    drive(16'h0001, 4'd10, 1'b0, 1'b1, 1'b1);
    drive(16'h0001, 4'd10, 1'b0, 1'b0, 1'b0);
    check("R12", "l_o dual load", l_o, 16'h0012);
    check("R12", "t_o dual load", t_o, 16'h0012);
    check("R12", "alu_o with new T", alu_o, 16'h0014);

    // R11: asynchronous clear mid-run
    @(posedge clk_i);
    #1 rst_ni = 1'b0;
    #0.5;
    check("R11", "l_o async clear", l_o, '0);
    check("R11", "t_o async clear", t_o, '0);
    check("R11", "l_carry_o async clear", {15'd0, l_carry_o}, '0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule